// File: doc/BRIEF.md
# Two-Level Virtual Address Translator

This block converts a 32-bit virtual address into a physical address by reading a two-level translation table from memory. The caller presents a virtual address, a write flag and the physical base of the top-level directory. The block then issues at most two word reads over a single-outstanding memory port: first the directory entry, then the leaf entry. It returns either a physical address or a two-bit fault code.

The address is split into a 10-bit directory index (bits 31:22), a 10-bit table index (bits 21:12) and a 12-bit page offset (bits 11:0). Every entry, at either level, carries a 20-bit frame number in bits 31:12 and flag bits in bits 11:0. A valid flag is checked at both levels. A writable flag is checked at the leaf, and only for writes. Addresses inside a fixed, directly mapped kernel window skip the walk entirely: the block subtracts the window base and reads no memory.

A result is presented for exactly one cycle with a done strobe. A new request is taken only while the block is idle.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `done` and `mem_req` are 0. A request is taken only in a cycle where both `req_valid` and `req_ready` are 1. `req_ready` is 0 from acceptance until after the done cycle, and it is 0 during the done cycle itself.
- R2: The first read address is the root value sampled at acceptance plus 4 times vaddr[31:22]. Changing `root_base` after acceptance has no effect on the walk.
- R3: The second read address is the directory entry's bits 31:12 followed by twelve zero bits, plus 4 times vaddr[21:12].
- R4: If the valid flag (entry bit 9 by default) of the directory entry is 0, the walk ends with fault code 2'b01 and no second read is issued.
- R5: If the valid flag of the leaf entry is 0, the result carries fault code 2'b10.
- R6: For a write (`req_write`=1) whose leaf is valid but has the writable flag (entry bit 10 by default) at 0, the fault code is 2'b11. A read ignores the writable flag.
- R7: For a valid leaf with no permission fault, the fault code is 2'b00 and `paddr` is the leaf's bits 31:12 followed by vaddr[11:0]. Other flag bits never appear in `paddr`.
- R8: A virtual address in [0x8000_0000, 0xA000_0000) gives `paddr` = vaddr − 0x8000_0000 and fault 2'b00. No memory read is issued, no permission check is made, and `done` rises in the cycle after acceptance. 0x7FFF_FFFF and 0xA000_0000 are walked normally.
- R9: `done` is high for exactly one cycle per accepted request, and `paddr` and `fault` are valid in that cycle. On any fault, `paddr` is 0.
- R10: `mem_req` is a one-cycle pulse, and no new `mem_req` is issued until the previous read has returned with `mem_rvalid`. A `mem_rvalid` that arrives while no read is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| root_base | input | 32 | Physical base of the directory, sampled on acceptance |
| mem_req | output | 1 | One-cycle read request pulse |
| mem_addr | output | 32 | Physical byte address of the entry to read |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Entry word returned by memory |
| done | output | 1 | One-cycle result strobe |
| paddr | output | 32 | Translated physical address (0 on fault) |
| fault | output | 2 | 00 none, 01 bad directory entry, 10 bad leaf entry, 11 write denied |

## Verification
Two things can coincide at the request edge: the done strobe of one translation and a new request that is already waiting. Another pair is a stray `mem_rvalid` pulse arriving in a cycle where no read is pending. The bench holds `req_valid` high across back-to-back requests, so a waiting request overlaps each done cycle. It then checks that the new request is not taken before `req_ready` returns, and that every done pulse matches exactly one queued expectation with the right number of reads. Stray read-return pulses with random data are injected while idle, and each translation is compared against a reference walk computed in the bench.

// File: rtl/walk_pkg.sv
package walk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_PDE,
    ST_WAIT_PDE,
    ST_FETCH_PTE,
    ST_WAIT_PTE,
    ST_DONE
  } walk_state_t;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_PDE   = 2'b01,
    FLT_PTE   = 2'b10,
    FLT_WRITE = 2'b11
  } walk_fault_t;

  // log2 of the entry size in bytes
  localparam int ENTRY_SZ_LOG2 = 2;

  // number of table levels walked
  localparam int NUM_LEVELS = 2;

endpackage

// File: rtl/walk_split.sv
module walk_split #(
  parameter int ADDR_W   = 32,
  parameter int DIR_BITS = 10,
  parameter int TBL_BITS = 10,
  parameter int OFF_BITS = 12,
  parameter bit [ADDR_W-1:0] KSEG_BASE = 'h8000_0000,
  parameter bit [ADDR_W-1:0] KSEG_SPAN = 'h2000_0000
) (
  input  logic [ADDR_W-1:0]   vaddr,
  output logic [DIR_BITS-1:0] dir_idx,
  output logic [TBL_BITS-1:0] tbl_idx,
  output logic [OFF_BITS-1:0] pg_off,
  output logic                in_kseg,
  output logic [ADDR_W-1:0]   kseg_paddr
);

  localparam int TBL_LSB = OFF_BITS;
  localparam int DIR_LSB = OFF_BITS + TBL_BITS;

  function automatic logic f_in_window(input logic [ADDR_W-1:0] va);
    logic [ADDR_W-1:0] rel;
    rel = va - KSEG_BASE;
    return (va >= KSEG_BASE) && (rel < KSEG_SPAN);
  endfunction

  function automatic logic [ADDR_W-1:0] f_strip(input logic [ADDR_W-1:0] va);
    return va - KSEG_BASE;
  endfunction

  assign dir_idx    = vaddr[DIR_LSB +: DIR_BITS];
  assign tbl_idx    = vaddr[TBL_LSB +: TBL_BITS];
  assign pg_off     = vaddr[OFF_BITS-1:0];
  assign in_kseg    = f_in_window(vaddr);
  assign kseg_paddr = f_strip(vaddr);

endmodule

// File: rtl/walk_entry_addr.sv
module walk_entry_addr #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 10,
  parameter int SZ_LOG2 = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] slot_addr
);

  function automatic logic [ADDR_W-1:0] f_slot(input logic [ADDR_W-1:0] b,
                                               input logic [IDX_W-1:0]  i);
    return b + (ADDR_W'(i) << SZ_LOG2);
  endfunction

  assign slot_addr = f_slot(base, idx);

endmodule

// File: rtl/walk_entry_chk.sv
module walk_entry_chk #(
  parameter int ADDR_W    = 32,
  parameter int OFF_BITS  = 12,
  parameter int VALID_BIT = 9,
  parameter int WRITE_BIT = 10
) (
  input  logic [ADDR_W-1:0] entry,
  output logic              present,
  output logic              writable,
  output logic [ADDR_W-1:0] frame_base
);

  function automatic logic [ADDR_W-1:0] f_frame(input logic [ADDR_W-1:0] e);
    return {e[ADDR_W-1:OFF_BITS], {OFF_BITS{1'b0}}};
  endfunction

  logic unused_flags;
  assign unused_flags = ^entry;

  assign present    = entry[VALID_BIT];
  assign writable   = entry[WRITE_BIT];
  assign frame_base = f_frame(entry);

endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 10,
  parameter int OFF_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_root,
  input  logic [IDX_W-1:0]    req_dir_idx,
  input  logic [IDX_W-1:0]    req_tbl_idx,
  input  logic [OFF_BITS-1:0] req_off,
  input  logic                req_in_kseg,
  input  logic [ADDR_W-1:0]   req_kseg_paddr,
  output logic [ADDR_W-1:0]   root_q_o,
  output logic [ADDR_W-1:0]   frame_q_o,
  output logic [IDX_W-1:0]    dir_q_o,
  output logic [IDX_W-1:0]    tbl_q_o,
  output logic                lvl_sel,
  output logic                mem_req,
  input  logic                mem_rvalid,
  input  logic                pde_present,
  input  logic [ADDR_W-1:0]   pde_frame,
  input  logic                pte_present,
  input  logic                pte_writable,
  input  logic [ADDR_W-1:0]   pte_frame,
  output logic                done,
  output logic [ADDR_W-1:0]   paddr,
  output logic [1:0]          fault
);

  walk_state_t state_q, state_d;
  walk_fault_t fault_q;
  logic [ADDR_W-1:0]   root_q, frame_q, paddr_q;
  logic [IDX_W-1:0]    dir_q, tbl_q;
  logic [OFF_BITS-1:0] off_q;
  logic                wr_q;

  // named internal events
  logic ev_accept, ev_accept_kseg, ev_pde_ret, ev_pte_ret;
  logic ev_pde_bad, ev_pte_bad, ev_write_denied, ev_leaf_ok;

  assign ev_accept       = (state_q == ST_IDLE) && req_valid;
  assign ev_accept_kseg  = ev_accept && req_in_kseg;
  assign ev_pde_ret      = (state_q == ST_WAIT_PDE) && mem_rvalid;
  assign ev_pte_ret      = (state_q == ST_WAIT_PTE) && mem_rvalid;
  assign ev_pde_bad      = ev_pde_ret && !pde_present;
  assign ev_pte_bad      = ev_pte_ret && !pte_present;
  assign ev_write_denied = ev_pte_ret && pte_present && wr_q && !pte_writable;
  assign ev_leaf_ok      = ev_pte_ret && pte_present && !(wr_q && !pte_writable);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (ev_accept) state_d = req_in_kseg ? ST_DONE : ST_FETCH_PDE;
      ST_FETCH_PDE: state_d = ST_WAIT_PDE;
      ST_WAIT_PDE:  if (mem_rvalid) state_d = pde_present ? ST_FETCH_PTE : ST_DONE;
      ST_FETCH_PTE: state_d = ST_WAIT_PTE;
      ST_WAIT_PTE:  if (mem_rvalid) state_d = ST_DONE;
      ST_DONE:      state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fault_q <= FLT_NONE;
      paddr_q <= '0;
      root_q  <= '0;
      frame_q <= '0;
      dir_q   <= '0;
      tbl_q   <= '0;
      off_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ev_accept) begin
        root_q  <= req_root;
        dir_q   <= req_dir_idx;
        tbl_q   <= req_tbl_idx;
        off_q   <= req_off;
        wr_q    <= req_write;
        fault_q <= FLT_NONE;
        paddr_q <= req_in_kseg ? req_kseg_paddr : '0;
      end
      if (ev_pde_ret) begin
        if (pde_present) frame_q <= pde_frame;
        else             fault_q <= FLT_PDE;
      end
      if (ev_pte_bad)      fault_q <= FLT_PTE;
      if (ev_write_denied) fault_q <= FLT_WRITE;
      if (ev_leaf_ok)      paddr_q <= {pte_frame[ADDR_W-1:OFF_BITS], off_q};
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign mem_req   = (state_q == ST_FETCH_PDE) || (state_q == ST_FETCH_PTE);
  assign lvl_sel   = (state_q == ST_FETCH_PTE) || (state_q == ST_WAIT_PTE);
  assign done      = (state_q == ST_DONE);
  assign paddr     = paddr_q;
  assign fault     = fault_q;
  assign root_q_o  = root_q;
  assign frame_q_o = frame_q;
  assign dir_q_o   = dir_q;
  assign tbl_q_o   = tbl_q;

  // read-pending tracker for the port protocol check
  logic pend_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         pend_q <= 1'b0;
    else if (mem_req)                   pend_q <= 1'b1;
    else if (ev_pde_ret || ev_pte_ret)  pend_q <= 1'b0;
  end

  a_r1_busy_while_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);
  a_r4_stop_after_bad_dir: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pde_bad |=> (done && fault == FLT_PDE && !mem_req));
  a_r5_bad_leaf: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pte_bad |=> (done && fault == FLT_PTE));
  a_r6_write_denied: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write_denied |=> (done && fault == FLT_WRITE));
  a_r7_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ev_leaf_ok |=> (done && fault == FLT_NONE && paddr[OFF_BITS-1:0] == off_q));
  a_r8_kseg_direct: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept_kseg |=> (done && fault == FLT_NONE && !mem_req));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault != FLT_NONE) |-> (paddr == '0));
  a_r10_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !pend_q);

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import walk_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DIR_BITS  = 10,
  parameter int TBL_BITS  = 10,
  parameter int OFF_BITS  = 12,
  parameter int VALID_BIT = 9,
  parameter int WRITE_BIT = 10,
  parameter bit [ADDR_W-1:0] KSEG_BASE = 'h8000_0000,
  parameter bit [ADDR_W-1:0] KSEG_SPAN = 'h2000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] root_base,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              done,
  output logic [ADDR_W-1:0] paddr,
  output logic [1:0]        fault
);

  localparam int IDX_W = (DIR_BITS > TBL_BITS) ? DIR_BITS : TBL_BITS;

  logic [DIR_BITS-1:0] s_dir;
  logic [TBL_BITS-1:0] s_tbl;
  logic [OFF_BITS-1:0] s_off;
  logic                s_kseg;
  logic [ADDR_W-1:0]   s_kpa;

  walk_split #(
    .ADDR_W(ADDR_W), .DIR_BITS(DIR_BITS), .TBL_BITS(TBL_BITS),
    .OFF_BITS(OFF_BITS), .KSEG_BASE(KSEG_BASE), .KSEG_SPAN(KSEG_SPAN)
  ) u_split (
    .vaddr(req_vaddr), .dir_idx(s_dir), .tbl_idx(s_tbl), .pg_off(s_off),
    .in_kseg(s_kseg), .kseg_paddr(s_kpa)
  );

  logic [ADDR_W-1:0] root_q, frame_q;
  logic [IDX_W-1:0]  dir_q, tbl_q;
  logic              lvl_sel;

  logic [ADDR_W-1:0] lvl_base     [NUM_LEVELS];
  logic [IDX_W-1:0]  lvl_idx      [NUM_LEVELS];
  logic [ADDR_W-1:0] lvl_addr     [NUM_LEVELS];
  logic [ADDR_W-1:0] lvl_frame    [NUM_LEVELS];
  logic              lvl_present  [NUM_LEVELS];
  logic              lvl_writable [NUM_LEVELS];

  assign lvl_base[0] = root_q;
  assign lvl_base[1] = frame_q;
  assign lvl_idx[0]  = dir_q;
  assign lvl_idx[1]  = tbl_q;

  for (genvar lv = 0; lv < NUM_LEVELS; lv++) begin : g_level
    walk_entry_addr #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SZ_LOG2(ENTRY_SZ_LOG2)
    ) u_addr (
      .base(lvl_base[lv]), .idx(lvl_idx[lv]), .slot_addr(lvl_addr[lv])
    );
    walk_entry_chk #(
      .ADDR_W(ADDR_W), .OFF_BITS(OFF_BITS),
      .VALID_BIT(VALID_BIT), .WRITE_BIT(WRITE_BIT)
    ) u_chk (
      .entry(mem_rdata), .present(lvl_present[lv]),
      .writable(lvl_writable[lv]), .frame_base(lvl_frame[lv])
    );
  end

  logic unused_dir_wr;
  assign unused_dir_wr = lvl_writable[0];

  walk_ctrl #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_BITS(OFF_BITS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_root(root_base),
    .req_dir_idx(IDX_W'(s_dir)), .req_tbl_idx(IDX_W'(s_tbl)),
    .req_off(s_off), .req_in_kseg(s_kseg), .req_kseg_paddr(s_kpa),
    .root_q_o(root_q), .frame_q_o(frame_q), .dir_q_o(dir_q), .tbl_q_o(tbl_q),
    .lvl_sel(lvl_sel), .mem_req(mem_req), .mem_rvalid(mem_rvalid),
    .pde_present(lvl_present[0]), .pde_frame(lvl_frame[0]),
    .pte_present(lvl_present[1]), .pte_writable(lvl_writable[1]),
    .pte_frame(lvl_frame[1]),
    .done(done), .paddr(paddr), .fault(fault)
  );

  assign mem_addr = lvl_sel ? lvl_addr[1] : lvl_addr[0];

endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;

  localparam logic [31:0] VF = 32'h0000_0200;  // valid flag, bit 9
  localparam logic [31:0] WF = 32'h0000_0400;  // writable flag, bit 10
  localparam logic [31:0] ROOT_A = 32'h0000_1000;
  localparam logic [31:0] ROOT_B = 32'h0000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] req_vaddr = '0, root_base = '0, mem_rdata = '0;
  logic req_ready, mem_req, done;
  logic [31:0] mem_addr, paddr;
  logic [1:0] fault;

  always #5 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .root_base(root_base),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .done(done), .paddr(paddr), .fault(fault)
  );

  typedef struct {
    logic [31:0] pa;
    logic [1:0]  flt;
    int          nrd;
    logic [31:0] a0, a1;
    bit          kern;
    int          cyc;
  } exp_t;

  exp_t sb[$];
  logic [31:0] mem [0:4095];
  int checks = 0, errors = 0, cyc = 0;
  int rd_cnt = 0;
  logic [31:0] rd_a [0:1];
  bit stray_en = 1'b0;
  bit prev_done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    if (a < 32'h4000) return mem[a[13:2]];
    return 32'h0;
  endfunction

  // reference walk, restated independently
  function automatic exp_t ref_walk(input logic [31:0] va, input bit wr,
                                    input logic [31:0] root);
    exp_t e;
    logic [31:0] d, t;
    e.pa = 0; e.flt = 2'b00; e.nrd = 0; e.a0 = 0; e.a1 = 0; e.kern = 0; e.cyc = 0;
    if (va[31:29] == 3'b100) begin
      e.kern = 1; e.pa = va ^ 32'h8000_0000;
      return e;
    end
    e.a0 = root + ((va >> 22) * 4);
    d = rd_word(e.a0); e.nrd = 1;
    if ((d & VF) == 0) begin e.flt = 2'b01; return e; end
    e.a1 = (d & 32'hFFFF_F000) + (((va >> 12) & 32'h3FF) * 4);
    t = rd_word(e.a1); e.nrd = 2;
    if ((t & VF) == 0) e.flt = 2'b10;
    else if (wr && (t & WF) == 0) e.flt = 2'b11;
    else e.pa = (t & 32'hFFFF_F000) | (va & 32'hFFF);
    return e;
  endfunction

  function automatic string tag_of(input exp_t e);
    if (e.kern) return "R8";
    case (e.flt)
      2'b01: return "R4";
      2'b10: return "R5";
      2'b11: return "R6";
      default: return "R7";
    endcase
  endfunction

  // memory model: one read pending at most, random latency, stray returns
  initial begin
    @(negedge clk);
    forever begin
      if (mem_req) begin
        if (rd_cnt < 2) rd_a[rd_cnt] = mem_addr;
        rd_cnt++;
        repeat (1 + ($urandom % 3)) @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata  = rd_word(rd_a[(rd_cnt - 1) % 2]);
        @(negedge clk);
        mem_rvalid = 1'b0;
        mem_rdata  = $urandom;
      end else begin
        if (stray_en && ($urandom % 4 == 0)) begin
          mem_rvalid = 1'b1;
          mem_rdata  = $urandom;
        end
        @(negedge clk);
        mem_rvalid = 1'b0;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        chk(!prev_done, "R9", "done longer than one cycle", 32'(prev_done), 0);
        chk(!req_ready, "R1", "ready during done", 32'(req_ready), 0);
        if (sb.size() == 0) begin
          chk(0, "R9", "done without request", 1, 0);
        end else begin
          exp_t e;
          string tg;
          e = sb.pop_front();
          tg = tag_of(e);
          chk(fault == e.flt, tg, "fault", 32'(fault), 32'(e.flt));
          chk(paddr == e.pa, (e.flt != 0) ? "R9" : tg, "paddr", paddr, e.pa);
          chk(rd_cnt == e.nrd, (e.kern ? "R8" : "R10"), "read count",
              rd_cnt, e.nrd);
          if (e.nrd >= 1 && rd_cnt >= 1)
            chk(rd_a[0] == e.a0, "R2", "directory address", rd_a[0], e.a0);
          if (e.nrd == 2 && rd_cnt == 2)
            chk(rd_a[1] == e.a1, "R3", "leaf address", rd_a[1], e.a1);
          if (e.kern)
            chk(cyc - e.cyc == 1, "R8", "bypass latency", cyc - e.cyc, 1);
        end
        rd_cnt = 0;
      end
      prev_done = done;
    end
  end

  task automatic do_req(input logic [31:0] va, input bit wr, input logic [31:0] root);
    exp_t e;
    req_valid = 1'b1;
    req_vaddr = va;
    req_write = wr;
    root_base = root;
    while (!req_ready) @(negedge clk);
    e = ref_walk(va, wr, root);
    e.cyc = cyc;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    root_base = $urandom | 32'h4000_0000;  // must be ignored (R2)
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    mem[(ROOT_A >> 2) + 0] = 32'h0000_2000 | VF;
    mem[(ROOT_A >> 2) + 1] = 32'h0000_3000 | VF | 32'h5;
    mem[(ROOT_A >> 2) + 2] = 32'h0000_2000 | WF;
    mem[(ROOT_A >> 2) + 5] = 32'h0000_3000 | VF | WF;
    mem[(ROOT_B >> 2) + 0] = 32'h0000_3000 | VF;
    mem[(ROOT_B >> 2) + 3] = 32'h0000_2000 | VF;
    for (int i = 0; i < 1024; i++) begin
      mem[32'h800 + i] = (((i * 37 + 16) & 32'hFFFFF) << 12) |
                         ((i % 3 != 0) ? VF : 0) | ((i % 4 < 2) ? WF : 0) | (i & 32'hF);
      mem[32'hC00 + i] = (((32'h50000 + i * 11) & 32'hFFFFF) << 12) |
                         ((i % 5 != 4) ? VF : 0) | ((i % 2 == 1) ? WF : 0) | 32'h800;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset ready", 32'(req_ready), 1);
    chk(done == 1'b0, "R1", "reset done", 32'(done), 0);
    chk(mem_req == 1'b0, "R1", "reset mem_req", 32'(mem_req), 0);

    // R8: direct window and its edges
    do_req(32'h8000_0000, 0, ROOT_A);
    do_req(32'h9FFF_FFFF, 1, ROOT_A);
    do_req(32'h8123_4567, 1, ROOT_A);
    do_req(32'h7FFF_FFFF, 0, ROOT_A);   // walked, bad directory
    do_req(32'hA000_0000, 0, ROOT_A);   // walked, bad directory
    // R4: directory invalid with writable flag set
    do_req(32'h0080_1234, 0, ROOT_A);
    // R5: leaf index 0 of table at 0x2000 is invalid
    do_req(32'h0000_0ABC, 0, ROOT_A);
    // R6: leaf index 2 valid, writable clear (2 % 4 >= 2)
    do_req(32'h0000_2FFF, 1, ROOT_A);
    do_req(32'h0000_2FFF, 0, ROOT_A);   // R6 read ignores flag
    // R7: leaf index 1 valid and writable
    do_req(32'h0000_1123, 1, ROOT_A);
    do_req(32'h0040_3456, 0, ROOT_A);
    do_req(32'h0140_7001, 1, ROOT_A);
    // R2: other root
    do_req(32'h0000_5010, 0, ROOT_B);
    do_req(32'h00C0_5010, 1, ROOT_B);
    drain();

    // back-to-back requests, random mix, stray returns (R10)
    stray_en = 1'b1;
    for (int n = 0; n < 300; n++) begin
      logic [31:0] va;
      logic [9:0] pd;
      case ($urandom % 7)
        0: pd = 10'd0;
        1: pd = 10'd1;
        2: pd = 10'd2;
        3: pd = 10'd5;
        4: pd = 10'd3;
        default: pd = 10'($urandom);
      endcase
      va = {pd, 10'($urandom), 12'($urandom)};
      if ($urandom % 8 == 0) va = 32'h8000_0000 | ($urandom & 32'h1FFF_FFFF);
      do_req(va, 1'($urandom), ($urandom % 5 == 0) ? ROOT_B : ROOT_A);
    end
    drain();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule